// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block switches up to seven power domains of a chip on and off in a fixed, safe order. Each domain has four control lines driven by the block: clock enable, output isolation, reset (active low) and a power-down request to the analog switch. Each domain also returns one acknowledge line from the switch, which is high once the domain is confirmed off. Software starts a sequence by writing a domain index and a direction to a command register. A hardware sequencer then steps through the control lines with a fixed settle interval between steps and waits, within a bounded time, for the switch to acknowledge.

Taking a domain down stops its clock, then isolates it, then holds it in reset, then removes power and waits for the acknowledge to rise. Bringing a domain up runs the same steps in reverse: power first, with a wait for the acknowledge to fall, then reset release, then isolation removal, then clock enable, then one last settle interval. The settle interval is `CLK_MHZ * SETTLE_US` cycles. Only one sequence runs at a time. While one runs, further commands are dropped and software writes to the control bits of the domain in flight are masked. An acknowledge that does not arrive in time ends the sequence and sets a sticky error for that domain, which software clears by writing 1 to it.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset every domain has clock enable 1, isolation 0, reset line 1 (released) and power-down 0. The sequencer is idle (`seq_busy` 0), the error register (0x08) reads 0, and the status register (0x04) shows every domain as on.
- R2: Writing the command register (0x00) with bits [3:0] = domain d and bit 8 = 0 starts power-off. The clock enable of d falls on the write edge and `seq_busy` rises on the same edge. Isolation rises S cycles later, the reset line falls S cycles after that, and power-down rises S cycles after that. `seq_busy` falls once the synchronized acknowledge of d is high.
- R3: A command with bit 8 = 1 starts power-on. Power-down of d falls and `seq_busy` rises on the write edge. Once the synchronized acknowledge of d is low, the reset line rises. Isolation falls S cycles later, the clock enable rises S cycles after that, and `seq_busy` falls S cycles after that.
- R4: If the acknowledge does not reach its target level within OFF_LIMIT cycles of the power-down rise (power-off) or ON_LIMIT cycles of the power-down fall (power-on), `seq_busy` falls exactly at that limit. Error bit d is set, the status field of d reads 3, and the control lines stay as they were.
- R5: Error register bits (0x08, bit d for domain d) are sticky. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R6: A command written while `seq_busy` is 1, or one that names a domain index of NUM_DOM or above, is ignored: no control line changes and no sequence starts.
- R7: Software writes to 0x18 (clock enable), 0x1C (reset, 1 = released), 0x20 (isolation) and 0x24 (power-down) set bit d of domain d directly on the write edge. The bit of the domain owned by a running sequence keeps its value. All four registers read back their current values.
- R8: The status register (0x04) holds a 2-bit field per domain at bits [2d+1:2d], plus a busy flag at bit 31. The field encodes 3 = error, 2 = in sequence, 1 = on (clock 1, reset released, isolation 0, power-down 0) and 0 = otherwise, with error taking priority.
- R9: The acknowledge register (0x28) reads the acknowledge inputs after a two-flop synchronizer, bit d for domain d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` (combinational) |
| dom_clk_en | output | NUM_DOM | Per-domain clock enable |
| dom_iso_en | output | NUM_DOM | Per-domain output isolation, 1 = isolated |
| dom_rst_n | output | NUM_DOM | Per-domain reset, 0 = held in reset |
| dom_pwr_dn | output | NUM_DOM | Per-domain power-down request to the switch |
| dom_pwr_ack | input | NUM_DOM | Per-domain switch acknowledge, 1 = confirmed off |
| seq_busy | output | 1 | A sequence is running |

## Verification
A wrong sequencer state shows at the domain pins within one settle interval. A step appears early, late, out of order or on the wrong domain, and every pin edge is matched against a queue of expected edges and their exact spacing. A wrong ownership or command mask shows as a control line that moves when nothing should, which the scoreboard reports in the cycle it happens. A wrong timeout count shows as `seq_busy` falling off the expected cycle. Wrong error or status state shows on the next read of 0x04 or 0x08.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int A_CMD  = 'h00;
  localparam int A_STAT = 'h04;
  localparam int A_ERR  = 'h08;
  localparam int A_CLK  = 'h18;
  localparam int A_RST  = 'h1C;
  localparam int A_ISO  = 'h20;
  localparam int A_PWR  = 'h24;
  localparam int A_ACK  = 'h28;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_CLK_OFF,
    OP_ISO_ON,
    OP_RST_HOLD,
    OP_PWR_CUT,
    OP_PWR_RESTORE,
    OP_RST_FREE,
    OP_ISO_OFF,
    OP_CLK_ON
  } seq_op_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DN_ISO,
    ST_DN_RST,
    ST_DN_PWR,
    ST_DN_ACK,
    ST_UP_ACK,
    ST_UP_ISO,
    ST_UP_CLK,
    ST_UP_FIN
  } seq_st_t;

  localparam logic [1:0] STAT_OFF = 2'd0;
  localparam logic [1:0] STAT_ON  = 2'd1;
  localparam logic [1:0] STAT_SEQ = 2'd2;
  localparam logic [1:0] STAT_ERR = 2'd3;

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int NUM_DOM    = 7,
  parameter int SETTLE_CYC = 500,
  parameter int OFF_LIMIT  = 1000,
  parameter int ON_LIMIT   = 10000,
  localparam int DOM_W     = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1,
  localparam int MAX_CNT   = (SETTLE_CYC > OFF_LIMIT) ?
                             ((SETTLE_CYC > ON_LIMIT) ? SETTLE_CYC : ON_LIMIT) :
                             ((OFF_LIMIT > ON_LIMIT) ? OFF_LIMIT : ON_LIMIT),
  localparam int CNT_W     = $clog2(MAX_CNT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [DOM_W-1:0]   cmd_dom,
  input  logic               cmd_on,
  input  logic [NUM_DOM-1:0] ack_s,
  output logic               busy,
  output logic [DOM_W-1:0]   act_dom,
  output logic               act_on,
  output logic [DOM_W-1:0]   op_dom,
  output seq_op_t            op,
  output logic               err_set
);

  seq_st_t          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DOM_W-1:0] dom_q, dom_d;
  logic             on_q, on_d;
  logic             settled;
  logic             ack_cur;

  assign settled = (cnt_q == CNT_W'(SETTLE_CYC - 1));
  assign ack_cur = ack_s[dom_q];

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q + 1'b1;
    dom_d   = dom_q;
    on_d    = on_q;
    op      = OP_NONE;
    err_set = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (go) begin
          dom_d = cmd_dom;
          on_d  = cmd_on;
          op    = cmd_on ? OP_PWR_RESTORE : OP_CLK_OFF;
          st_d  = cmd_on ? ST_UP_ACK : ST_DN_ISO;
        end
      end
      ST_DN_ISO: if (settled) begin
        op = OP_ISO_ON;    st_d = ST_DN_RST; cnt_d = '0;
      end
      ST_DN_RST: if (settled) begin
        op = OP_RST_HOLD;  st_d = ST_DN_PWR; cnt_d = '0;
      end
      ST_DN_PWR: if (settled) begin
        op = OP_PWR_CUT;   st_d = ST_DN_ACK; cnt_d = '0;
      end
      ST_DN_ACK: begin
        if (ack_cur) begin
          st_d = ST_IDLE;
        end else if (cnt_q == CNT_W'(OFF_LIMIT - 1)) begin
          st_d = ST_IDLE; err_set = 1'b1;
        end
      end
      ST_UP_ACK: begin
        if (!ack_cur) begin
          op = OP_RST_FREE; st_d = ST_UP_ISO; cnt_d = '0;
        end else if (cnt_q == CNT_W'(ON_LIMIT - 1)) begin
          st_d = ST_IDLE; err_set = 1'b1;
        end
      end
      ST_UP_ISO: if (settled) begin
        op = OP_ISO_OFF;   st_d = ST_UP_CLK; cnt_d = '0;
      end
      ST_UP_CLK: if (settled) begin
        op = OP_CLK_ON;    st_d = ST_UP_FIN; cnt_d = '0;
      end
      ST_UP_FIN: if (settled) begin
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      dom_q <= '0;
      on_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      dom_q <= dom_d;
      on_q  <= on_d;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign act_dom = dom_q;
  assign act_on  = on_q;
  assign op_dom  = busy ? dom_q : cmd_dom;

endmodule

// File: rtl/pwr_seq_regs.sv
module pwr_seq_regs
  import pwr_seq_pkg::*;
#(
  parameter int NUM_DOM = 7,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  localparam int DOM_W  = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic               busy,
  input  logic [DOM_W-1:0]   act_dom,
  input  logic [DOM_W-1:0]   op_dom,
  input  seq_op_t            op,
  input  logic               err_set,
  input  logic [NUM_DOM-1:0] ack_s,
  output logic [NUM_DOM-1:0] clk_q,
  output logic [NUM_DOM-1:0] iso_q,
  output logic [NUM_DOM-1:0] rel_q,
  output logic [NUM_DOM-1:0] pwr_q,
  output logic [NUM_DOM-1:0] err_q
);

  logic [NUM_DOM-1:0] clk_d, iso_d, rel_d, pwr_d, err_d;
  logic [NUM_DOM-1:0] own, wv;
  logic               wr_clk, wr_rst, wr_iso, wr_pwr, wr_err;
  logic [DATA_W-1:0]  stat_w;

  assign wv     = wdata[NUM_DOM-1:0];
  assign wr_clk = wr_en && (addr == ADDR_W'(A_CLK));
  assign wr_rst = wr_en && (addr == ADDR_W'(A_RST));
  assign wr_iso = wr_en && (addr == ADDR_W'(A_ISO));
  assign wr_pwr = wr_en && (addr == ADDR_W'(A_PWR));
  assign wr_err = wr_en && (addr == ADDR_W'(A_ERR));

  always_comb begin
    own = '0;
    if (busy) own[act_dom] = 1'b1;
  end

  always_comb begin
    clk_d = clk_q;
    iso_d = iso_q;
    rel_d = rel_q;
    pwr_d = pwr_q;
    err_d = err_q;
    if (wr_clk) clk_d = (wv & ~own) | (clk_q & own);
    if (wr_rst) rel_d = (wv & ~own) | (rel_q & own);
    if (wr_iso) iso_d = (wv & ~own) | (iso_q & own);
    if (wr_pwr) pwr_d = (wv & ~own) | (pwr_q & own);
    if (wr_err) err_d = err_q & ~wv;
    unique case (op)
      OP_CLK_OFF:     clk_d[op_dom] = 1'b0;
      OP_ISO_ON:      iso_d[op_dom] = 1'b1;
      OP_RST_HOLD:    rel_d[op_dom] = 1'b0;
      OP_PWR_CUT:     pwr_d[op_dom] = 1'b1;
      OP_PWR_RESTORE: pwr_d[op_dom] = 1'b0;
      OP_RST_FREE:    rel_d[op_dom] = 1'b1;
      OP_ISO_OFF:     iso_d[op_dom] = 1'b0;
      OP_CLK_ON:      clk_d[op_dom] = 1'b1;
      default: ;
    endcase
    if (err_set) err_d[op_dom] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= '1;
      iso_q <= '0;
      rel_q <= '1;
      pwr_q <= '0;
      err_q <= '0;
    end else begin
      clk_q <= clk_d;
      iso_q <= iso_d;
      rel_q <= rel_d;
      pwr_q <= pwr_d;
      err_q <= err_d;
    end
  end

  always_comb begin
    stat_w = '0;
    for (int d = 0; d < NUM_DOM; d++) begin
      if (err_q[d])                              stat_w[2*d +: 2] = STAT_ERR;
      else if (own[d])                           stat_w[2*d +: 2] = STAT_SEQ;
      else if (clk_q[d] && rel_q[d] && !iso_q[d] && !pwr_q[d])
                                                 stat_w[2*d +: 2] = STAT_ON;
      else                                       stat_w[2*d +: 2] = STAT_OFF;
    end
    stat_w[DATA_W-1] = busy;
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_W'(A_STAT): rdata = stat_w;
      ADDR_W'(A_ERR):  rdata[NUM_DOM-1:0] = err_q;
      ADDR_W'(A_CLK):  rdata[NUM_DOM-1:0] = clk_q;
      ADDR_W'(A_RST):  rdata[NUM_DOM-1:0] = rel_q;
      ADDR_W'(A_ISO):  rdata[NUM_DOM-1:0] = iso_q;
      ADDR_W'(A_PWR):  rdata[NUM_DOM-1:0] = pwr_q;
      ADDR_W'(A_ACK):  rdata[NUM_DOM-1:0] = ack_s;
      default:         rdata = '0;
    endcase
  end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int NUM_DOM   = 7,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int CLK_MHZ   = 100,
  parameter int SETTLE_US = 5,
  parameter int OFF_LIMIT = 1000,
  parameter int ON_LIMIT  = 10000,
  localparam int DOM_W    = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1,
  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [NUM_DOM-1:0] dom_clk_en,
  output logic [NUM_DOM-1:0] dom_iso_en,
  output logic [NUM_DOM-1:0] dom_rst_n,
  output logic [NUM_DOM-1:0] dom_pwr_dn,
  input  logic [NUM_DOM-1:0] dom_pwr_ack,
  output logic               seq_busy
);

  logic [NUM_DOM-1:0] ack_s;
  logic [NUM_DOM-1:0] err_vec;
  logic               cmd_wr, cmd_ok, go;
  logic [DOM_W-1:0]   act_dom, op_dom;
  logic               act_on, err_set;
  seq_op_t            op;

  assign cmd_wr = wr_en && (addr == ADDR_W'(A_CMD));
  assign cmd_ok = (int'(wdata[3:0]) < NUM_DOM);
  assign go     = cmd_wr && cmd_ok && !seq_busy;

  pwr_seq_sync #(.W(NUM_DOM), .STAGES(2)) ack_sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (dom_pwr_ack),
    .dout (ack_s)
  );

  pwr_seq_fsm #(
    .NUM_DOM   (NUM_DOM),
    .SETTLE_CYC(SETTLE_CYC),
    .OFF_LIMIT (OFF_LIMIT),
    .ON_LIMIT  (ON_LIMIT)
  ) fsm_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go),
    .cmd_dom(wdata[DOM_W-1:0]),
    .cmd_on (wdata[8]),
    .ack_s  (ack_s),
    .busy   (seq_busy),
    .act_dom(act_dom),
    .act_on (act_on),
    .op_dom (op_dom),
    .op     (op),
    .err_set(err_set)
  );

  pwr_seq_regs #(
    .NUM_DOM(NUM_DOM),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) regs_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .busy   (seq_busy),
    .act_dom(act_dom),
    .op_dom (op_dom),
    .op     (op),
    .err_set(err_set),
    .ack_s  (ack_s),
    .clk_q  (dom_clk_en),
    .iso_q  (dom_iso_en),
    .rel_q  (dom_rst_n),
    .pwr_q  (dom_pwr_dn),
    .err_q  (err_vec)
  );

endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk #(
  parameter int NUM_DOM = 7,
  localparam int DOM_W  = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               seq_busy,
  input logic [DOM_W-1:0]   act_dom,
  input logic               act_on,
  input logic [NUM_DOM-1:0] err_vec,
  input logic [NUM_DOM-1:0] dom_clk_en,
  input logic [NUM_DOM-1:0] dom_iso_en,
  input logic [NUM_DOM-1:0] dom_rst_n,
  input logic [NUM_DOM-1:0] dom_pwr_dn
);

  // R6
  owner_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && $past(seq_busy)) |-> $stable(act_dom));

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    // R2
    dn_iso_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy && act_dom == DOM_W'(d) && !act_on && $rose(dom_iso_en[d]))
        |-> !dom_clk_en[d]);
    // R2
    dn_pwr_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy && act_dom == DOM_W'(d) && !act_on && $rose(dom_pwr_dn[d]))
        |-> (!dom_rst_n[d] && dom_iso_en[d] && !dom_clk_en[d]));
    // R3
    up_clk_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy && act_dom == DOM_W'(d) && act_on && $rose(dom_clk_en[d]))
        |-> (dom_rst_n[d] && !dom_iso_en[d] && !dom_pwr_dn[d]));
    // R4
    err_ends_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_vec[d]) |-> $fell(seq_busy));
  end

endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(.NUM_DOM(NUM_DOM)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .seq_busy  (seq_busy),
  .act_dom   (act_dom),
  .act_on    (act_on),
  .err_vec   (err_vec),
  .dom_clk_en(dom_clk_en),
  .dom_iso_en(dom_iso_en),
  .dom_rst_n (dom_rst_n),
  .dom_pwr_dn(dom_pwr_dn)
);

// File: tb/pwr_seq_ctrl_tb_top.sv
module pwr_seq_ctrl_tb_top;

  localparam int ND  = 7;
  localparam int S   = 10;
  localparam int OFL = 40;
  localparam int ONL = 60;

  logic          clk, rst_n, wr_en;
  logic [7:0]    addr;
  logic [31:0]   wdata, rdata;
  logic [ND-1:0] dom_clk_en, dom_iso_en, dom_rst_n, dom_pwr_dn;
  logic [ND-1:0] ack_q;
  logic          seq_busy;

  pwr_seq_ctrl #(
    .NUM_DOM(ND), .CLK_MHZ(2), .SETTLE_US(5),
    .OFF_LIMIT(OFL), .ON_LIMIT(ONL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .dom_clk_en(dom_clk_en), .dom_iso_en(dom_iso_en),
    .dom_rst_n(dom_rst_n), .dom_pwr_dn(dom_pwr_dn),
    .dom_pwr_ack(ack_q), .seq_busy(seq_busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // Power switch model: acknowledge follows power-down after a delay
  int       ack_dly  [ND];
  logic     ack_hold [ND];
  int       ack_cnt  [ND];

  always @(posedge clk) begin
    for (int d = 0; d < ND; d++) begin
      if (!rst_n) begin
        ack_q[d]   <= 1'b0;
        ack_cnt[d] <= 0;
      end else if (!ack_hold[d] && (ack_q[d] != dom_pwr_dn[d])) begin
        if (ack_cnt[d] >= ack_dly[d]) begin
          ack_q[d]   <= dom_pwr_dn[d];
          ack_cnt[d] <= 0;
        end else begin
          ack_cnt[d] <= ack_cnt[d] + 1;
        end
      end else begin
        ack_cnt[d] <= 0;
      end
    end
  end

  // Scoreboard of expected pin edges. sig: 0 clk,1 iso,2 rst,3 pwr,4 busy
  typedef struct {
    int    dom;
    int    sig;
    int    val;
    int    gap;
    string req;
  } ev_t;
  ev_t exp_q[$];

  task automatic push(int dom, int sig, int val, int gap, string req);
    ev_t e;
    e.dom = dom; e.sig = sig; e.val = val; e.gap = gap; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic exp_off(int d, bit tmo);
    push(d, 0, 0, -1, "R2");
    push(0, 4, 1, -1, "R2");
    push(d, 1, 1, S, "R2");
    push(d, 2, 0, S, "R2");
    push(d, 3, 1, S, "R2");
    if (tmo) push(0, 4, 0, OFL, "R4");
    else     push(0, 4, 0, -1, "R2");
  endtask

  task automatic exp_on(int d, bit tmo);
    push(d, 3, 0, -1, "R3");
    push(0, 4, 1, -1, "R3");
    if (tmo) begin
      push(0, 4, 0, ONL, "R4");
    end else begin
      push(d, 2, 1, -1, "R3");
      push(d, 1, 0, S, "R3");
      push(d, 0, 1, S, "R3");
      push(0, 4, 0, S, "R3");
    end
  endtask

  bit mon_on = 1'b0;

  task automatic see(int dom, int sig, int val, int cyc, inout int last);
    ev_t e;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL R6/R7: unexpected edge dom %0d sig %0d to %0d (expected none)",
               dom, sig, val);
    end else begin
      e = exp_q.pop_front();
      if (e.dom != dom || e.sig != sig || e.val != val ||
          (e.gap >= 0 && e.gap != cyc - last)) begin
        n_bad++;
        $display("FAIL %s: edge dom %0d sig %0d val %0d gap %0d, expected dom %0d sig %0d val %0d gap %0d",
                 e.req, dom, sig, val, cyc - last, e.dom, e.sig, e.val, e.gap);
      end
    end
    last = cyc;
  endtask

  initial begin : monitor
    logic [ND-1:0] pc, pi, pr, pp;
    logic pb;
    int cyc, last;
    cyc = 0; last = 0;
    wait (mon_on);
    @(negedge clk);
    pc = dom_clk_en; pi = dom_iso_en; pr = dom_rst_n; pp = dom_pwr_dn; pb = seq_busy;
    forever begin
      @(negedge clk);
      cyc++;
      for (int d = 0; d < ND; d++) begin
        if (dom_clk_en[d] != pc[d]) see(d, 0, int'(dom_clk_en[d]), cyc, last);
        if (dom_iso_en[d] != pi[d]) see(d, 1, int'(dom_iso_en[d]), cyc, last);
        if (dom_rst_n[d]  != pr[d]) see(d, 2, int'(dom_rst_n[d]),  cyc, last);
        if (dom_pwr_dn[d] != pp[d]) see(d, 3, int'(dom_pwr_dn[d]), cyc, last);
      end
      if (seq_busy != pb) see(0, 4, int'(seq_busy), cyc, last);
      pc = dom_clk_en; pi = dom_iso_en; pr = dom_rst_n; pp = dom_pwr_dn; pb = seq_busy;
    end
  end

  task automatic reg_wr(logic [7:0] a, logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!seq_busy) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    report();
  end

  initial begin : stim
    logic [31:0] v;
    for (int d = 0; d < ND; d++) begin
      ack_dly[d] = 2; ack_hold[d] = 1'b0;
    end
    wr_en = 1'b0; addr = 8'h00; wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 clk_en", {25'b0, dom_clk_en}, 32'h7F);
    chk("R1 iso_en", {25'b0, dom_iso_en}, 32'h00);
    chk("R1 rst_n",  {25'b0, dom_rst_n},  32'h7F);
    chk("R1 pwr_dn", {25'b0, dom_pwr_dn}, 32'h00);
    chk("R1 busy",   {31'b0, seq_busy},   32'h0);
    reg_rd(8'h04, v); chk("R1 status", v, 32'h1555);
    reg_rd(8'h08, v); chk("R1 error", v, 32'h0);
    mon_on = 1'b1;
    repeat (3) @(negedge clk);

    // R2 power-off of domain 2, with rejected traffic meanwhile (R6, R7)
    ack_dly[2] = 5;
    exp_off(2, 1'b0);
    reg_wr(8'h00, 32'h002);
    reg_rd(8'h04, v); chk("R8 status in sequence", v, 32'h8000_1565);
    reg_wr(8'h00, 32'h003);   // R6 busy reject
    reg_wr(8'h18, 32'h7F);    // R7 owned bit masked
    wait_idle();
    reg_rd(8'h18, v); chk("R7 owned clk bit kept", v, 32'h7B);
    reg_rd(8'h24, v); chk("R2 pwr reg", v, 32'h04);
    reg_rd(8'h28, v); chk("R9 ack reg", v, 32'h04);
    reg_rd(8'h04, v); chk("R8 status off", v, 32'h1545);

    // R3 power-on of domain 2
    ack_dly[2] = 3;
    exp_on(2, 1'b0);
    reg_wr(8'h00, 32'h102);
    wait_idle();
    reg_rd(8'h04, v); chk("R3 status on", v, 32'h1555);
    reg_rd(8'h28, v); chk("R9 ack cleared", v, 32'h00);

    // R6 invalid domain index
    reg_wr(8'h00, 32'h107);
    reg_wr(8'h00, 32'h00F);
    repeat (3) @(negedge clk);
    chk("R6 invalid index no start", {31'b0, seq_busy}, 32'h0);

    // R7 direct writes when idle
    push(5, 0, 0, -1, "R7");
    reg_wr(8'h18, 32'h5F);
    reg_rd(8'h18, v); chk("R7 clk readback", v, 32'h5F);
    reg_rd(8'h04, v); chk("R8 status direct off", v, 32'h1155);
    push(5, 0, 1, -1, "R7");
    reg_wr(8'h18, 32'h7F);
    repeat (2) @(negedge clk);

    // R4 power-off timeout on domain 4
    ack_hold[4] = 1'b1;
    exp_off(4, 1'b1);
    reg_wr(8'h00, 32'h004);
    wait_idle();
    reg_rd(8'h04, v); chk("R4 status error", v, 32'h1755);
    reg_rd(8'h08, v); chk("R4 error bit", v, 32'h10);
    reg_rd(8'h24, v); chk("R4 pwr left set", v, 32'h10);
    reg_wr(8'h08, 32'h01);
    reg_rd(8'h08, v); chk("R5 write 0 keeps", v, 32'h10);
    reg_wr(8'h08, 32'h10);
    reg_rd(8'h08, v); chk("R5 write 1 clears", v, 32'h00);
    reg_rd(8'h04, v); chk("R5 status after clear", v, 32'h1455);

    // R3 power-on of domain 4, acknowledge already low
    exp_on(4, 1'b0);
    reg_wr(8'h00, 32'h104);
    wait_idle();
    ack_hold[4] = 1'b0;
    reg_rd(8'h04, v); chk("R3 status on again", v, 32'h1555);

    // R4 power-on timeout on domain 6
    exp_off(6, 1'b0);
    reg_wr(8'h00, 32'h006);
    wait_idle();
    ack_hold[6] = 1'b1;
    exp_on(6, 1'b1);
    reg_wr(8'h00, 32'h106);
    wait_idle();
    reg_rd(8'h04, v); chk("R4 on-timeout status", v, 32'h3555);
    reg_rd(8'h08, v); chk("R4 on-timeout error", v, 32'h40);
    reg_wr(8'h08, 32'h40);
    reg_rd(8'h04, v); chk("R5 status cleared off", v, 32'h0555);
    reg_rd(8'h28, v); chk("R9 ack held", v, 32'h40);

    repeat (5) @(negedge clk);
    chk("R2 R3 all expected edges seen", exp_q.size(), 32'd0);
    report();
  end

endmodule